// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block watches the stream of memory write cycles that a host issues to a parallel flash device. It picks out the multi-cycle unlock sequences that start a byte program, a sector erase, a block erase or a whole-chip erase. Any cycle that does not fit the expected step sends it back to standby. A recognised operation is handed to an internal busy timer. When the timer expires, the block issues one commit to the array port. A program commit is a read-modify-write that can only clear bits. An erase commit is a single pulse with a scope code, and the array decides the extent of the sector or block.

While an operation runs, every write cycle is ignored. Reads return polling status instead of data: bit 7 is the complement of the bit being written, and bit 6 alternates on each read. Once the timer has expired, reads return array data again. A mode input enables chip erase only for the address-multiplexed programmer setting. A permit input from the surrounding protection logic can veto any recognised operation.

Top module: `flash_unlock_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `rd_data`, `arr_we` and `arr_erase` are all 0.
- R2: The writes (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0) followed by a fourth write (A,D) start a program. `busy` then stays high for exactly PROG_CYC cycles, and the final cycle commits to address A.
- R3: A program commit stores the old array byte AND D. A 0 bit is never returned to 1 by a program.
- R4: The erase sequence is (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), then a final write. A final byte of 0x30 at any address gives a sector erase, with `arr_scope` = 1. A final byte of 0x50 gives a block erase, with `arr_scope` = 2. `busy` lasts ERASE_CYC cycles and `arr_addr` carries the final-cycle address at commit.
- R5: A final erase write of 0x10 at 0x5555 starts a chip erase (`arr_scope` = 3) only when `mux_mode` is 1. With `mux_mode` at 0, the sequence is dropped and `busy` stays low.
- R6: A write that does not match the expected step returns the sequencer to standby. Later writes must restart from the first step.
- R7: A recognised operation that arrives while `permit` is 0 is dropped: no busy period and no commit.
- R8: While `busy` is high, every write cycle is ignored, including a complete program sequence.
- R9: A read accepted while `busy` is high returns, on the next cycle, bit 7 = complement of the programmed bit 7, with erased data taken as 0xFF. Bit 6 differs from the previous busy read, and bits 5..0 are 0.
- R10: A read accepted while `busy` is low returns `arr_rdata` for `rd_addr` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | write cycle strobe |
| wr_addr | input | ADDR_W | write cycle address |
| wr_data | input | 8 | write cycle data |
| rd_en | input | 1 | read strobe |
| rd_addr | input | ADDR_W | read address |
| rd_data | output | 8 | read result or polling status, one cycle after rd_en |
| mux_mode | input | 1 | 1 = programmer mode, chip erase allowed |
| permit | input | 1 | 0 = protection vetoes the recognised operation |
| busy | output | 1 | operation in progress |
| arr_addr | output | ADDR_W | array address (target while busy, else rd_addr) |
| arr_rdata | input | 8 | array data at arr_addr |
| arr_we | output | 1 | program commit strobe |
| arr_wdata | output | 8 | byte to store on program commit |
| arr_erase | output | 1 | erase commit strobe |
| arr_scope | output | 2 | 1 sector, 2 block, 3 chip |

## Verification
The bench builds the block with PROG_CYC = 8 and ERASE_CYC = 24, so every program and erase completes within a few dozen cycles. With these values the exact busy length can be measured for each kind of operation. Several back-to-back polling reads fit inside one program, which shows bit 6 alternating. A full program sequence can also be issued in the middle of an erase. A byte-wide array model in the bench applies commits by scope, with a 16-byte sector, a 64-byte block and 256 bytes in total.

// File: rtl/fus_pkg.sv
package fus_pkg;

    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CMD_KEY_A   = 8'hAA;
    localparam logic [DATA_W-1:0] CMD_KEY_B   = 8'h55;
    localparam logic [DATA_W-1:0] CMD_PROGRAM = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_ERASE   = 8'h80;
    localparam logic [DATA_W-1:0] CMD_SECTOR  = 8'h30;
    localparam logic [DATA_W-1:0] CMD_BLOCK   = 8'h50;
    localparam logic [DATA_W-1:0] CMD_CHIP    = 8'h10;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PGM_DATA,
        ST_ERS_KEY1,
        ST_ERS_KEY2,
        ST_ERS_FINAL
    } seq_state_e;

    typedef enum logic [1:0] {
        SC_BYTE   = 2'd0,
        SC_SECTOR = 2'd1,
        SC_BLOCK  = 2'd2,
        SC_CHIP   = 2'd3
    } op_scope_e;

    typedef struct packed {
        op_scope_e          scope;
        logic [DATA_W-1:0]  data;
    } op_t;

    function automatic logic is_erase(input op_scope_e s);
        return s != SC_BYTE;
    endfunction

endpackage

// File: rtl/fus_decoder.sv
module fus_decoder
    import fus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              mux_mode,
    input  logic              permit,
    output logic              launch,
    output op_t               launch_op,
    output logic [ADDR_W-1:0] launch_addr
);

    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

    seq_state_e st, st_nxt;
    logic       hit_a, hit_b, on_a;
    logic       found;
    op_scope_e  found_scope;

    assign on_a  = (wr_addr == ADR_A);
    assign hit_a = on_a && (wr_data == CMD_KEY_A);
    assign hit_b = (wr_addr == ADR_B) && (wr_data == CMD_KEY_B);

    always_comb begin
        st_nxt      = st;
        found       = 1'b0;
        found_scope = SC_BYTE;
        if (wr_en && !busy) begin
            st_nxt = ST_IDLE;
            unique case (st)
                ST_IDLE:     if (hit_a) st_nxt = ST_KEY1;
                ST_KEY1:     if (hit_b) st_nxt = ST_KEY2;
                ST_KEY2: begin
                    if (on_a && wr_data == CMD_PROGRAM)    st_nxt = ST_PGM_DATA;
                    else if (on_a && wr_data == CMD_ERASE) st_nxt = ST_ERS_KEY1;
                end
                ST_PGM_DATA: found = 1'b1;
                ST_ERS_KEY1: if (hit_a) st_nxt = ST_ERS_KEY2;
                ST_ERS_KEY2: if (hit_b) st_nxt = ST_ERS_FINAL;
                ST_ERS_FINAL: begin
                    if (wr_data == CMD_SECTOR) begin
                        found       = 1'b1;
                        found_scope = SC_SECTOR;
                    end else if (wr_data == CMD_BLOCK) begin
                        found       = 1'b1;
                        found_scope = SC_BLOCK;
                    end else if (wr_data == CMD_CHIP && on_a && mux_mode) begin
                        found       = 1'b1;
                        found_scope = SC_CHIP;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    assign launch          = found && permit;
    assign launch_op.scope = found_scope;
    assign launch_op.data  = is_erase(found_scope) ? {DATA_W{1'b1}} : wr_data;
    assign launch_addr     = wr_addr;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    // R8: the sequencer sits in standby for the whole busy period
    a_r8_idle_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> st == ST_IDLE);

    // R5: a chip-scope launch needs programmer mode
    a_r5_chip_needs_mode: assert property (@(posedge clk) disable iff (rst)
        (launch && launch_op.scope == SC_CHIP) |-> mux_mode);

    // R6: a launch only ever follows a completed sequence
    a_r6_launch_after_seq: assert property (@(posedge clk) disable iff (rst)
        launch |-> (st == ST_PGM_DATA || st == ST_ERS_FINAL));

endmodule

// File: rtl/fus_busy_timer.sv
module fus_busy_timer
    import fus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PROG_CYC  = 200,
    parameter int ERASE_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  op_t               launch_op,
    input  logic [ADDR_W-1:0] launch_addr,
    output logic              busy,
    output logic              done,
    output op_t               cur_op,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cur_op   <= '0;
            cur_addr <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (launch) begin
            busy     <= 1'b1;
            cnt      <= is_erase(launch_op.scope) ? ERASE_LOAD : PROG_LOAD;
            cur_op   <= launch_op;
            cur_addr <= launch_addr;
        end
    end

    // R2: busy holds until the count is used up
    a_r2_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);

    // R7: a busy period begins only from a permitted write cycle
    a_r7_start_needs_permit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(launch));

    // R8: operation parameters are frozen during the busy period
    a_r8_op_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> ($stable(cur_op) && $stable(cur_addr)));

endmodule

// File: rtl/fus_status.sv
module fus_status
    import fus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              busy,
    input  op_t               cur_op,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data
);

    logic tgl;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            tgl     <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rd_data <= {~cur_op.data[DATA_W-1], ~tgl, {(DATA_W-2){1'b0}}};
                tgl     <= ~tgl;
            end else begin
                rd_data <= arr_rdata;
            end
        end
    end

    // R9: each busy read flips the toggle state
    a_r9_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> tgl != $past(tgl));

    // R9: idle reads leave the toggle state untouched
    a_r9_toggle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && busy) |=> $stable(tgl));

endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
    import fus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PROG_CYC  = 200,
    parameter int ERASE_CYC = 50000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              mux_mode,
    input  logic              permit,
    output logic              busy,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_rdata,
    output logic              arr_we,
    output logic [7:0]        arr_wdata,
    output logic              arr_erase,
    output logic [1:0]        arr_scope
);

    logic              launch, done;
    op_t               launch_op, cur_op;
    logic [ADDR_W-1:0] launch_addr, cur_addr;

    fus_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .mux_mode(mux_mode), .permit(permit),
        .launch(launch), .launch_op(launch_op), .launch_addr(launch_addr)
    );

    fus_busy_timer #(
        .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_tmr (
        .clk(clk), .rst(rst),
        .launch(launch), .launch_op(launch_op), .launch_addr(launch_addr),
        .busy(busy), .done(done), .cur_op(cur_op), .cur_addr(cur_addr)
    );

    fus_status u_sts (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .busy(busy), .cur_op(cur_op),
        .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

    assign arr_addr  = busy ? cur_addr : rd_addr;
    assign arr_we    = done && !is_erase(cur_op.scope);
    assign arr_wdata = arr_rdata & cur_op.data;
    assign arr_erase = done && is_erase(cur_op.scope);
    assign arr_scope = cur_op.scope;

    // R1: at most one commit kind per cycle, and only while busy
    a_r1_commit_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arr_we, arr_erase}) && ((arr_we || arr_erase) -> busy));

    // R2: a commit ends the busy period on the next cycle
    a_r2_commit_ends_busy: assert property (@(posedge clk) disable iff (rst)
        (arr_we || arr_erase) |=> !busy);

    // R3: a program commit never sets a bit that the array holds at 0
    a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> ((arr_wdata | arr_rdata) == arr_rdata));

endmodule

// File: tb/tb_flash_unlock_seq.sv
module tb_flash_unlock_seq;

    localparam int ADDR_W = 16;
    localparam int PROG_N = 8;
    localparam int ERASE_N = 24;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en, rd_en, mux_mode, permit;
    logic [ADDR_W-1:0] wr_addr, rd_addr, arr_addr;
    logic [7:0]        wr_data, rd_data, arr_rdata, arr_wdata;
    logic              busy, arr_we, arr_erase;
    logic [1:0]        arr_scope;

    int n_checks = 0;
    int n_fail   = 0;
    int busy_seen = 0;
    bit finished = 1'b0;

    logic [7:0] mem [256];

    always #4 clk = ~clk;

    flash_unlock_seq #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N)) dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .mux_mode(mux_mode), .permit(permit), .busy(busy),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .arr_we(arr_we), .arr_wdata(arr_wdata),
        .arr_erase(arr_erase), .arr_scope(arr_scope)
    );

    // behavioural array: 16-byte sector, 64-byte block, 256 bytes in all
    assign arr_rdata = mem[arr_addr[7:0]];
    always @(posedge clk) begin
        if (busy) busy_seen <= busy_seen + 1;
        if (arr_we) mem[arr_addr[7:0]] <= arr_wdata;
        if (arr_erase) begin
            for (int i = 0; i < 256; i++) begin
                if (arr_scope == 2'd3 ||
                   (arr_scope == 2'd2 && i[7:6] == arr_addr[7:6]) ||
                   (arr_scope == 2'd1 && i[7:4] == arr_addr[7:4]))
                    mem[i] <= 8'hFF;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wcyc(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic wend();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic seq_program(input logic [15:0] a, input logic [7:0] d);
        wcyc(16'h5555, 8'hAA); wcyc(16'h2AAA, 8'h55); wcyc(16'h5555, 8'hA0);
        wcyc(a, d);
        wend();
    endtask

    task automatic seq_erase(input logic [15:0] a, input logic [7:0] d);
        wcyc(16'h5555, 8'hAA); wcyc(16'h2AAA, 8'h55); wcyc(16'h5555, 8'h80);
        wcyc(16'h5555, 8'hAA); wcyc(16'h2AAA, 8'h55); wcyc(a, d);
        wend();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 arr_we", arr_we, 0);
        check("R1 arr_erase", arr_erase, 0);
    endtask

    task automatic t_program();
        int n; logic [7:0] v;
        seq_program(16'h0101, 8'h5C);
        wait_idle(n);
        check("R2 program busy length", n, PROG_N);
        rd(16'h0101, v);
        check("R10 read after program", v, 8'h5C);
        seq_program(16'h0101, 8'hA7);
        wait_idle(n);
        rd(16'h0101, v);
        check("R3 old AND new", v, 8'h04);
    endtask

    task automatic t_poll();
        logic [7:0] v1, v2; int n;
        seq_program(16'h0042, 8'h3F);
        rd(16'h0042, v1);
        rd(16'h0042, v2);
        check("R9 bit7 complement", v1[7], 1);
        check("R9 low bits zero", v1[5:0], 0);
        check("R9 bit6 toggles", v1[6] ^ v2[6], 1);
        wait_idle(n);
        rd(16'h0042, v1);
        check("R9 true data after done", v1, 8'h3F);
    endtask

    task automatic t_sector_busy_writes();
        int n; logic [7:0] v;
        seq_program(16'h0085, 8'h00); wait_idle(n);
        seq_program(16'h0030, 8'h3C); wait_idle(n);
        seq_erase(16'h0080, 8'h30);
        rd(16'h0080, v);
        check("R9 erase poll bit7", v[7], 0);
        seq_program(16'h0031, 8'h00);
        wait_idle(n);
        rd(16'h0085, v);
        check("R4 sector erased", v, 8'hFF);
        rd(16'h0031, v);
        check("R8 program during busy ignored", v, 8'hFF);
        rd(16'h0030, v);
        check("R4 outside sector kept", v, 8'h3C);
    endtask

    task automatic t_block();
        int n; logic [7:0] v;
        seq_program(16'h00D0, 8'h12); wait_idle(n);
        seq_erase(16'h00C4, 8'h50);
        wait_idle(n);
        check("R4 erase busy length", n, ERASE_N);
        rd(16'h00D0, v);
        check("R4 block erased", v, 8'hFF);
        rd(16'h0030, v);
        check("R4 outside block kept", v, 8'h3C);
    endtask

    task automatic t_chip();
        int n; logic [7:0] v;
        mux_mode = 1'b0;
        busy_seen = 0;
        seq_erase(16'h5555, 8'h10);
        repeat (3) @(negedge clk);
        check("R5 chip erase refused without mode", busy_seen, 0);
        rd(16'h0030, v);
        check("R5 data kept", v, 8'h3C);
        mux_mode = 1'b1;
        seq_erase(16'h5555, 8'h10);
        wait_idle(n);
        check("R5 chip erase busy", n, ERASE_N);
        rd(16'h0030, v);
        check("R5 chip erased", v, 8'hFF);
        mux_mode = 1'b0;
    endtask

    task automatic t_abort();
        int n; logic [7:0] v;
        busy_seen = 0;
        wcyc(16'h5555, 8'hAA); wcyc(16'h2AAA, 8'h55); wcyc(16'h5555, 8'h90);
        wcyc(16'h2AAA, 8'h55); wcyc(16'h5555, 8'hA0); wcyc(16'h0010, 8'h00);
        wend();
        repeat (3) @(negedge clk);
        check("R6 bad step aborts", busy_seen, 0);
        rd(16'h0010, v);
        check("R6 no write after abort", v, 8'hFF);
        wcyc(16'h5554, 8'hAA);
        seq_program(16'h0010, 8'h66);
        wait_idle(n);
        rd(16'h0010, v);
        check("R6 fresh sequence after abort", v, 8'h66);
    endtask

    task automatic t_permit();
        logic [7:0] v;
        permit = 1'b0;
        busy_seen = 0;
        seq_program(16'h0011, 8'h00);
        repeat (3) @(negedge clk);
        check("R7 vetoed no busy", busy_seen, 0);
        rd(16'h0011, v);
        check("R7 vetoed no write", v, 8'hFF);
        permit = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0;
        wr_data = '0; mux_mode = 1'b0; permit = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_poll();
        t_sector_busy_writes();
        t_block();
        t_abort();
        t_permit();
        t_chip();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule